// File: doc/BRIEF.md
# Accumulator Rotate and Decimal Adjust Unit

This unit carries out the single-byte operations that act on the accumulator alone, and computes the flag byte that each one leaves. It has four rotates (circular left, circular right, left through carry and right through carry), a bitwise complement, set carry, complement carry, and a decimal adjust. The decimal adjust corrects the accumulator after packed-BCD addition or subtraction. The unit is purely combinational. The datapath feeds it the accumulator, the current flag byte and a 3-bit operation code. It returns the new accumulator and the new flag byte in the same cycle.

The flag byte uses the layout shared with the main ALU. Sign is bit 7, zero is bit 6, a copy of data bit 5 is bit 5, half carry is bit 4, a copy of data bit 3 is bit 3, parity/overflow is bit 2, subtract is bit 1 and carry is bit 0. Instruction fetch, decode and memory access stay with the surrounding core.

Top module: `accu_adjust_unit`

## Requirements
- R1: With op code 0 (circular left), the result is the accumulator rotated left by one, with old bit 7 placed in result bit 0 and in flag bit 0 (carry). Flag layout: S=7, Z=6, X5=5, H=4, X3=3, PV=2, N=1, C=0.
- R2: With op code 1 (circular right), the result is the accumulator rotated right by one, with old bit 0 placed in result bit 7 and in carry.
- R3: With op code 2 (left through carry), the old carry enters result bit 0 and old bit 7 becomes the new carry.
- R4: With op code 3 (right through carry), the old carry enters result bit 7 and old bit 0 becomes the new carry.
- R5: All four rotates (codes 0 to 3) clear H (bit 4) and N (bit 1) and keep S, Z and PV (bits 7, 6, 2) as they came in. They copy result bits 5 and 3 into flag bits 5 and 3.
- R6: With op code 5 (complement), every accumulator bit is inverted. H and N are set, S, Z, PV and C are kept, and flag bits 5 and 3 copy the result.
- R7: With op code 6 (set carry), the accumulator is unchanged, C is 1, and H and N are 0. S, Z and PV are kept, and flag bits 5 and 3 copy the accumulator.
- R8: With op code 7 (complement carry), the accumulator is unchanged, H takes the old C, C is inverted and N is 0. S, Z and PV are kept, and flag bits 5 and 3 copy the accumulator.
- R9: With op code 4 and N=0, the result is the accumulator plus a correction. The correction gets 0x06 when the low digit exceeds 9 or H is set, and 0x60 when the accumulator exceeds 0x99 or C is set. C out is set in the latter case and otherwise keeps its incoming value.
- R10: With op code 4 and N=1, the same correction (and the same C out) is subtracted from the accumulator instead of added.
- R11: After op code 4, S is result bit 7, Z is set only for a zero result, PV is 1 for an even count of ones in the result, N is kept, and flag bits 5 and 3 copy the result. H is (low digit > 9) when N=0, and (old H and low digit < 6) when N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_in | input | 8 | Accumulator value before the operation |
| flags_in | input | 8 | Flag byte before the operation |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| acc_out | output | 8 | Accumulator value after the operation |
| flags_out | output | 8 | Flag byte after the operation |

## Verification
Every accumulator value is swept under every operation code, with all eight H/N/C combinations and alternating backgrounds for S, Z, PV and the copy bits. This exposes any flag that is wrongly passed through or wrongly overwritten. For decimal adjust, the bench targets low digits of 9 and 10, accumulators of 0x99 and 0x9A, and the subtract path with H set and low digits around 6. A design that checks the upper digit after adding the low correction, or that forgets to invert the correction when N=1, produces wrong BCD digits or a wrong carry there. For the through-carry rotates, the bench drives both carry values, so a design that treats them as circular rotates shows a wrong bit 0 or bit 7. For complement carry, it checks that H gets the old carry and not the new one.

// File: rtl/accu_pkg.sv
package accu_pkg;

    localparam int DATA_W   = 8;
    localparam int OP_W     = 3;
    localparam int DIGIT_W  = DATA_W / 2;
    localparam int DIGIT_MAX = 9;
    localparam int BCD_LIMIT = 16'h99;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ROT_LC  = 3'd0,
        OP_ROT_RC  = 3'd1,
        OP_ROT_LT  = 3'd2,
        OP_ROT_RT  = 3'd3,
        OP_DEC_ADJ = 3'd4,
        OP_INVERT  = 3'd5,
        OP_SET_C   = 3'd6,
        OP_FLIP_C  = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic copy5;
        logic half;
        logic copy3;
        logic par_ov;
        logic subtr;
        logic carry;
    } flag_t;

    typedef struct packed {
        word_t value;
        flag_t flags;
    } acc_res_t;

    function automatic logic even_ones(word_t v);
        return ~(^v);
    endfunction

    function automatic flag_t take_copies(flag_t f, word_t src);
        flag_t r;
        r       = f;
        r.copy5 = src[5];
        r.copy3 = src[3];
        return r;
    endfunction

    function automatic logic is_rotate(acc_op_e op);
        return (op == OP_ROT_LC) || (op == OP_ROT_RC) ||
               (op == OP_ROT_LT) || (op == OP_ROT_RT);
    endfunction

endpackage

// File: rtl/accu_rotator.sv
module accu_rotator
    import accu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] val,
    input  logic         cin,
    input  logic         go_right,
    input  logic         through_c,
    output logic [W-1:0] res,
    output logic         cout
);
    logic fill_left;
    logic fill_right;

    always_comb begin
        fill_left  = through_c ? cin : val[W-1];
        fill_right = through_c ? cin : val[0];
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign res[i] = go_right ? val[i+1] : fill_left;
            end else if (i == W-1) begin : g_msb
                assign res[i] = go_right ? fill_right : val[i-1];
            end else begin : g_mid
                assign res[i] = go_right ? val[i+1] : val[i-1];
            end
        end
    endgenerate

    assign cout = go_right ? val[0] : val[W-1];

endmodule

// File: rtl/accu_flagops.sv
module accu_flagops
    import accu_pkg::*;
(
    input  acc_op_e  op,
    input  word_t    val,
    input  flag_t    fin,
    output acc_res_t res
);
    word_t inv_val;

    assign inv_val = ~val;

    always_comb begin
        res.value = val;
        res.flags = fin;
        unique case (op)
            OP_INVERT: begin
                res.value      = inv_val;
                res.flags      = take_copies(fin, inv_val);
                res.flags.half = 1'b1;
                res.flags.subtr = 1'b1;
            end
            OP_SET_C: begin
                res.flags       = take_copies(fin, val);
                res.flags.carry = 1'b1;
                res.flags.half  = 1'b0;
                res.flags.subtr = 1'b0;
            end
            OP_FLIP_C: begin
                res.flags       = take_copies(fin, val);
                res.flags.half  = fin.carry;
                res.flags.carry = ~fin.carry;
                res.flags.subtr = 1'b0;
            end
            default: begin
                res.value = val;
                res.flags = fin;
            end
        endcase
    end

endmodule

// File: rtl/accu_decadj.sv
module accu_decadj
    import accu_pkg::*;
(
    input  word_t    val,
    input  flag_t    fin,
    output acc_res_t res
);
    localparam int LOW_HI = DIGIT_W - 1;

    logic [DIGIT_W-1:0] low_digit;
    logic               fix_low;
    logic               fix_high;
    word_t              correction;
    word_t              adjusted;
    logic               half_next;

    always_comb begin
        low_digit  = val[LOW_HI:0];
        fix_low    = (low_digit > DIGIT_W'(DIGIT_MAX)) || fin.half;
        fix_high   = (val > DATA_W'(BCD_LIMIT)) || fin.carry;
        correction = {(fix_high ? 4'h6 : 4'h0), (fix_low ? 4'h6 : 4'h0)};
        adjusted   = fin.subtr ? (val - correction) : (val + correction);
        half_next  = fin.subtr ? (fin.half && (low_digit < 4'd6))
                               : (low_digit > DIGIT_W'(DIGIT_MAX));
    end

    always_comb begin
        res.value        = adjusted;
        res.flags        = take_copies(fin, adjusted);
        res.flags.sign   = adjusted[DATA_W-1];
        res.flags.zero   = (adjusted == '0);
        res.flags.par_ov = even_ones(adjusted);
        res.flags.half   = half_next;
        res.flags.carry  = fix_high;
        res.flags.subtr  = fin.subtr;
    end

endmodule

// File: rtl/accu_adjust_unit.sv
module accu_adjust_unit
    import accu_pkg::*;
(
    input  logic [7:0] acc_in,
    input  logic [7:0] flags_in,
    input  logic [2:0] op_sel,
    output logic [7:0] acc_out,
    output logic [7:0] flags_out
);
    acc_op_e  op;
    flag_t    fin;
    word_t    rot_val;
    logic     rot_c;
    acc_res_t misc_res;
    acc_res_t bcd_res;
    acc_res_t rot_res;
    acc_res_t final_res;

    assign op  = acc_op_e'(op_sel);
    assign fin = flag_t'(flags_in);

    accu_rotator #(.W(DATA_W)) u_rot (
        .val       (acc_in),
        .cin       (fin.carry),
        .go_right  (op_sel[0]),
        .through_c (op_sel[1]),
        .res       (rot_val),
        .cout      (rot_c)
    );

    accu_flagops u_misc (
        .op  (op),
        .val (acc_in),
        .fin (fin),
        .res (misc_res)
    );

    accu_decadj u_bcd (
        .val (acc_in),
        .fin (fin),
        .res (bcd_res)
    );

    always_comb begin
        rot_res.value       = rot_val;
        rot_res.flags       = take_copies(fin, rot_val);
        rot_res.flags.carry = rot_c;
        rot_res.flags.half  = 1'b0;
        rot_res.flags.subtr = 1'b0;
    end

    always_comb begin
        if (is_rotate(op))           final_res = rot_res;
        else if (op == OP_DEC_ADJ)   final_res = bcd_res;
        else                         final_res = misc_res;
    end

    assign acc_out   = final_res.value;
    assign flags_out = final_res.flags;

    always_comb begin
        if (op == OP_ROT_LC) begin
            assert_rlc_wrap_R1: assert (acc_out[0] == acc_in[7] && flags_out[0] == acc_in[7])
                else $error("circular left wrap broken");
        end
        if (op == OP_ROT_RT) begin
            assert_rrt_carry_in_R4: assert (acc_out[7] == flags_in[0] && flags_out[0] == acc_in[0])
                else $error("right-through-carry path broken");
        end
        if (is_rotate(op)) begin
            assert_rot_keep_R5: assert (flags_out[4] == 1'b0 && flags_out[1] == 1'b0 &&
                                        flags_out[7] == flags_in[7] && flags_out[6] == flags_in[6] &&
                                        flags_out[2] == flags_in[2])
                else $error("rotate flag policy broken");
        end
        if (op == OP_INVERT) begin
            assert_inv_bits_R6: assert ((acc_out ^ acc_in) == 8'hFF && flags_out[4] && flags_out[1])
                else $error("complement broken");
        end
        if (op == OP_FLIP_C) begin
            assert_flip_half_R8: assert (flags_out[4] == flags_in[0] && flags_out[0] != flags_in[0])
                else $error("complement carry broken");
        end
        if (op == OP_DEC_ADJ) begin
            assert_bcd_zero_R11: assert (flags_out[6] == (acc_out == 8'h00) && flags_out[7] == acc_out[7])
                else $error("decimal adjust S/Z broken");
        end
    end

endmodule

// File: tb/accu_adjust_unit_test.sv
module accu_adjust_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic [7:0] acc_in = '0;
    logic [7:0] flags_in = '0;
    logic [2:0] op_sel = '0;
    logic [7:0] acc_out;
    logic [7:0] flags_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    accu_adjust_unit uut (
        .acc_in    (acc_in),
        .flags_in  (flags_in),
        .op_sel    (op_sel),
        .acc_out   (acc_out),
        .flags_out (flags_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ones(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic model(input int op, input int a, input int f,
                         output int ra, output int rf);
        int c = f & 1;
        int n = (f >> 1) & 1;
        int h = (f >> 4) & 1;
        int keep = f & 8'hC4;
        int corr, cout, hout, lo;
        case (op)
            0: begin ra = ((a << 1) | (a >> 7)) & 255; rf = keep | (a >> 7) | (ra & 8'h28); end
            1: begin ra = (a >> 1) | ((a & 1) << 7);   rf = keep | (a & 1)  | (ra & 8'h28); end
            2: begin ra = ((a << 1) | c) & 255;        rf = keep | (a >> 7) | (ra & 8'h28); end
            3: begin ra = (a >> 1) | (c << 7);         rf = keep | (a & 1)  | (ra & 8'h28); end
            4: begin
                lo = a % 16;
                corr = 0;
                cout = c;
                if (lo > 9 || h == 1) corr += 6;
                if (a > 153 || c == 1) begin corr += 96; cout = 1; end
                ra = (n == 1) ? (a - corr + 256) % 256 : (a + corr) % 256;
                hout = (n == 1) ? ((h == 1 && lo < 6) ? 1 : 0) : ((lo > 9) ? 1 : 0);
                rf = (ra & 8'hA8) | ((ra == 0) ? 8'h40 : 0) | (hout << 4)
                   | (((ones(ra) % 2) == 0) ? 4 : 0) | (n << 1) | cout;
            end
            5: begin ra = 255 - a; rf = (f & 8'hC5) | (ra & 8'h28) | 8'h12; end
            6: begin ra = a; rf = keep | (a & 8'h28) | 1; end
            default: begin ra = a; rf = keep | (a & 8'h28) | (c << 4) | (1 - c); end
        endcase
    endtask

    function automatic string acc_tag(int op, int f);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return (((f >> 1) & 1) == 1) ? "R10" : "R9";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic string flag_tag(int op);
        case (op)
            0, 1, 2, 3: return "R5";
            4: return "R11";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply_and_check(input int op, input int a, input int f);
        int ea, ef;
        @(negedge clk);
        op_sel = op[2:0];
        acc_in = a[7:0];
        flags_in = f[7:0];
        model(op, a, f, ea, ef);
        @(posedge clk);
        #1;
        checks++;
        if (acc_out != ea[7:0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%02h f=%02h acc actual=%02h expected=%02h",
                     acc_tag(op, f), op, a, f, acc_out, ea[7:0]);
        end
        checks++;
        if (flags_out != ef[7:0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%02h f=%02h flags actual=%02h expected=%02h",
                     flag_tag(op), op, a, f, flags_out, ef[7:0]);
        end
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG_CYCLES && !finished) begin
                fails++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // idle inputs: circular left of zero (R1), all flags clear
        apply_and_check(0, 0, 0);
        // directed BCD corners (R9, R10, R11)
        apply_and_check(4, 8'h9A, 8'h00);
        apply_and_check(4, 8'h99, 8'h00);
        apply_and_check(4, 8'h99, 8'h01);
        apply_and_check(4, 8'h0F, 8'h12);
        apply_and_check(4, 8'h15, 8'h12);
        apply_and_check(4, 8'h00, 8'h13);
        // full sweep: every op, every accumulator, every H/N/C combination
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int fi = 0; fi < 8; fi++) begin
                    int bg = (((a + fi) & 1) == 1) ? 8'hEC : 8'h00;
                    int f = bg | (((fi >> 2) & 1) << 4) | (((fi >> 1) & 1) << 1) | (fi & 1);
                    apply_and_check(op, a, f);
                end
            end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule